// File: doc/BRIEF.md
# Supply-Qualified Reset Sequencer

This block turns a digital "supply above trip" indication from an external comparator into the processor reset. From power-up, reset stays active until the supply has been above the trip point without a break for a fixed stabilization interval. After that it drops back into reset whenever the supply falls away. A supply dip at any point during the interval starts the count again from zero, so only an unbroken good period releases reset.

The block also gates the rest of the chip while the supply is low. One output tells the serial interface to drop any transfer in progress and to refuse new ones. A second output blocks nonvolatile writes from starting. A write that is already running is not disturbed. A watchdog timeout request from outside also drives reset active. Reset is given in two polarities, active low and active high, and the pads are outside this block.

Entry into the low-supply state is asynchronous, so reset asserts without waiting for a clock edge. Exit passes through a two-stage synchronizer and is then qualified by the stabilization counter.

Top module: `rsq_reset_seq`

## Requirements
- R1: While `rst` is high and for the cycles after it until the supply qualifies, `reset_n` is 0, `reset_hi` is 1 and `bus_abort` is 1.
- R2: When `vcc_ok` goes to 0, `reset_n` goes to 0, `bus_abort` goes to 1 and `wr_block` goes to 1 (if `wr_busy` is 0), all without waiting for a clock edge.
- R3: With `vcc_ok` held at 1, reset is released at rising clock edge number STAB_CYCLES+2. Edge 1 is the first rising edge that sees `vcc_ok` at 1. Reset is still active after edge STAB_CYCLES+1.
- R4: If `vcc_ok` goes to 0 for any time during the stabilization count, the count starts again from zero. Release then needs the full STAB_CYCLES+2 edges counted from the new rise.
- R5: `bus_abort` is 1 while the supply is low. It clears at the second rising edge that sees `vcc_ok` at 1, independent of the stabilization count.
- R6: `wr_block` is 1 exactly when the supply is low (as seen by `bus_abort`) and `wr_busy` is 0. A write that is running when the supply drops keeps `wr_block` at 0 until `wr_busy` falls.
- R7: A 1 on `wdt_req` at a rising edge makes reset active for the following clock cycle, even when the supply is good.
- R8: `reset_hi` is always the complement of `reset_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forces the low-supply state |
| vcc_ok | input | 1 | Comparator output, 1 when the supply is above the trip point |
| wdt_req | input | 1 | Watchdog timeout request |
| wr_busy | input | 1 | A nonvolatile write is in progress |
| reset_n | output | 1 | Processor reset, active low |
| reset_hi | output | 1 | Processor reset, active high |
| bus_abort | output | 1 | Terminate and refuse serial transfers |
| wr_block | output | 1 | Inhibit the start of a nonvolatile write |

## Verification
The hardest case to reach is a supply dip that falls between two clock edges partway through the stabilization count. Such a dip is never seen at an edge, yet it must clear the count. The bench drops `vcc_ok` one nanosecond after a falling edge and raises it again before the next rising edge. It then counts edges from that point to show that the full interval has to pass again. The bench also drops the supply while `wr_busy` is held, to show that a running write is left alone.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Supply qualification phase, as seen by the sequencer
    typedef enum logic [1:0] {
        PH_LOW    = 2'd0,
        PH_SETTLE = 2'd1,
        PH_GOOD   = 2'd2
    } rsq_phase_e;

    // Gating bundle handed to the output stage
    typedef struct packed {
        logic supply_low;   // synchronized low-supply flag
        logic qualified;    // stabilization interval completed
        logic wdt_hit;      // registered watchdog request
    } rsq_ctl_t;

    function automatic int unsigned rsq_cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rsq_supply_sync.sv
module rsq_supply_sync (
    input  logic clk,
    input  logic rst,
    input  logic vcc_ok,
    output logic supply_low
);
    logic meta_q;
    logic low_q;

    // Asynchronous entry on a low supply, synchronous two-stage exit
    always_ff @(posedge clk or negedge vcc_ok) begin
        if (!vcc_ok) begin
            meta_q <= 1'b1;
            low_q  <= 1'b1;
        end else if (rst) begin
            meta_q <= 1'b1;
            low_q  <= 1'b1;
        end else begin
            meta_q <= 1'b0;
            low_q  <= meta_q;
        end
    end

    assign supply_low = low_q;

    // R5: the flag can only clear one edge after the first stage cleared
    a_r5_two_stage_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(low_q) |-> !$past(meta_q));

endmodule

// File: rtl/rsq_stab_timer.sv
module rsq_stab_timer
    import rsq_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 20_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low,
    output logic       qualified,
    output rsq_phase_e phase
);
    localparam int unsigned CW = rsq_cnt_bits(STAB_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt_q;

    // Any low indication clears the count at once (R4)
    always_ff @(posedge clk or posedge supply_low) begin
        if (supply_low) begin
            cnt_q <= '0;
        end else if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qualified = (cnt_q == LIMIT);

    always_comb begin
        if (supply_low)     phase = PH_LOW;
        else if (qualified) phase = PH_GOOD;
        else                phase = PH_SETTLE;
    end

    // R4: the count never jumps forward by more than one step
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> ($past(cnt_q) == cnt_q || $past(cnt_q) == cnt_q - 1'b1));

    // R3: qualification is only reached from the step just below it
    a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> ($past(cnt_q) == LIMIT - 1'b1));

endmodule

// File: rtl/rsq_out_stage.sv
module rsq_out_stage
    import rsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rsq_ctl_t ctl,
    input  logic     wr_busy,
    output logic     reset_n,
    output logic     reset_hi,
    output logic     bus_abort,
    output logic     wr_block
);
    logic hold;

    assign hold      = ctl.supply_low | ~ctl.qualified | ctl.wdt_hit;
    assign reset_hi  = hold;
    assign reset_n   = ~hold;
    assign bus_abort = ctl.supply_low;
    assign wr_block  = ctl.supply_low & ~wr_busy;

    // R6: a write busy across an edge is never blocked at that edge
    a_r6_running_write: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_busy) && wr_busy) |-> !wr_block);

endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq
    import rsq_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic vcc_ok,
    input  logic wdt_req,
    input  logic wr_busy,
    output logic reset_n,
    output logic reset_hi,
    output logic bus_abort,
    output logic wr_block
);
    rsq_ctl_t   ctl;
    rsq_phase_e phase;
    logic       low;
    logic       qual;
    logic       wdt_q;

    rsq_supply_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .vcc_ok     (vcc_ok),
        .supply_low (low)
    );

    rsq_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .supply_low (low),
        .qualified  (qual),
        .phase      (phase)
    );

    always_ff @(posedge clk) begin
        if (rst) wdt_q <= 1'b0;
        else     wdt_q <= wdt_req;
    end

    assign ctl = '{supply_low: low, qualified: qual, wdt_hit: wdt_q};

    rsq_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .wr_busy   (wr_busy),
        .reset_n   (reset_n),
        .reset_hi  (reset_hi),
        .bus_abort (bus_abort),
        .wr_block  (wr_block)
    );

    // R2: a low supply always shows as reset and bus abort
    a_r2_low_holds_reset: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |-> (!reset_n && bus_abort));

    // R7: a watchdog request at an edge yields reset after it
    a_r7_wdt_reset: assert property (@(posedge clk) disable iff (rst)
        $past(wdt_req) |-> !reset_n);

    // R3: release happens only with a good supply in the good phase
    a_r3_release_good: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_n) |-> (vcc_ok && phase == PH_GOOD));

    // R8: the two polarities never agree
    a_r8_polarity: assert property (@(posedge clk) disable iff (rst)
        reset_n != reset_hi);

endmodule

// File: tb/rsq_reset_seq_test.sv
module rsq_reset_seq_test;
    localparam int unsigned STAB = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok = 1'b0;
    logic wdt_req = 1'b0;
    logic wr_busy = 1'b0;
    logic reset_n, reset_hi, bus_abort, wr_block;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rsq_reset_seq #(.STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .wdt_req(wdt_req),
        .wr_busy(wr_busy), .reset_n(reset_n), .reset_hi(reset_hi),
        .bus_abort(bus_abort), .wr_block(wr_block)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Rise vcc_ok at a falling edge and verify the release edge
    task automatic qualify(input string req);
        vcc_ok = 1'b1;
        edges(1);
        chk({req, " abort edge1"}, bus_abort, 1'b1);
        edges(1);
        chk({req, " abort edge2"}, bus_abort, 1'b0);
        edges(STAB - 1);
        chk({req, " held edge N+1"}, reset_n, 1'b0);
        edges(1);
        chk({req, " released edge N+2"}, reset_n, 1'b1);
        chk("R8 polarity", reset_hi, 1'b0);
    endtask

    task automatic t_reset_state;
        edges(3);
        chk("R1 reset_n", reset_n, 1'b0);
        chk("R1 reset_hi", reset_hi, 1'b1);
        chk("R1 bus_abort", bus_abort, 1'b1);
        chk("R6 blocked idle", wr_block, 1'b1);
        rst = 1'b0;
        edges(2);
        chk("R1 held after rst", reset_n, 1'b0);
    endtask

    task automatic t_power_up;
        qualify("R3 R5");
    endtask

    task automatic t_brownout;
        edges(2);
        #2 vcc_ok = 1'b0;
        #1;
        chk("R2 async reset_n", reset_n, 1'b0);
        chk("R2 async abort", bus_abort, 1'b1);
        chk("R2 async block", wr_block, 1'b1);
        chk("R8 polarity low", reset_hi, 1'b1);
        edges(3);
        qualify("R3 after brownout");
    endtask

    task automatic t_glitch;
        vcc_ok = 1'b0;
        edges(2);
        vcc_ok = 1'b1;
        edges(STAB / 2);
        #1 vcc_ok = 1'b0;
        #2 vcc_ok = 1'b1;
        @(negedge clk);
        chk("R4 restart abort", bus_abort, 1'b1);
        edges(STAB);
        chk("R4 held edge N+1", reset_n, 1'b0);
        edges(1);
        chk("R4 released edge N+2", reset_n, 1'b1);
    endtask

    task automatic t_watchdog;
        wdt_req = 1'b1;
        #2;
        chk("R7 not before edge", reset_n, 1'b1);
        @(negedge clk);
        chk("R7 reset after edge", reset_n, 1'b0);
        chk("R7 abort untouched", bus_abort, 1'b0);
        wdt_req = 1'b0;
        @(negedge clk);
        chk("R7 released", reset_n, 1'b1);
    endtask

    task automatic t_write;
        wr_busy = 1'b1;
        edges(1);
        #1 vcc_ok = 1'b0;
        #1;
        chk("R6 busy not blocked", wr_block, 1'b0);
        chk("R5 abort low", bus_abort, 1'b1);
        edges(2);
        chk("R6 still not blocked", wr_block, 1'b0);
        wr_busy = 1'b0;
        #1;
        chk("R6 block after busy", wr_block, 1'b1);
        @(negedge clk);
        vcc_ok = 1'b1;
        edges(2);
        chk("R6 block cleared", wr_block, 1'b0);
        edges(STAB);
        chk("R3 released after write", reset_n, 1'b1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_power_up();
        t_brownout();
        t_glitch();
        t_watchdog();
        t_write();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule